// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator

This block holds one hardware instruction breakpoint and checks every fetched instruction address against it. Software-side logic writes a 64-bit breakpoint value register and a control register. Whenever either register is written, the block decodes the pair into a compare address and an armed flag and stores the result. Every fetch is then compared against that stored address.

Only the two address-match breakpoint types raise a hit. Context, virtual-machine, linked-context and mismatch types never hit, and neither do the reserved type codes. A half-word select field chooses the match point: either the word-aligned base address or the base plus 2. A fetch hits only when it starts exactly at the chosen address. A fetch that merely overlaps the covered bytes does not hit.

The hit flag is combinational on the fetch inputs. It is raised in the same cycle as the fetch that matches.

Top module: `ibp_comparator`

## Requirements
- R1: After reset both registers read as zero, the breakpoint is disarmed, and no fetch raises `hit` until the registers are written.
- R2: When control bit 0 (enable) is 0, no fetch raises `hit`, whatever the other fields hold.
- R3: Control bits 23:20 give the type. Type 0 (unlinked address match) and type 1 (linked address match) both compare against the fetch address.
- R4: Every other type code, 2 through 15, produces no hit.
- R5: The compare base is the value register with bits 1:0 forced to zero. With select field (control bits 8:5) equal to 4'b0011 or 4'b1111, a fetch at the base hits.
- R6: With select equal to 4'b1100, a fetch at base+2 hits.
- R7: A select of 4'b0000, or any value other than 0011, 1100 or 1111, leaves the breakpoint disarmed.
- R8: A hit needs the fetch to start exactly at the compare address. With select 0011 a fetch at base+2 does not hit, and with select 1100 a fetch at the base does not hit.
- R9: All 64 address bits take part in the compare. A difference in bit 63 alone prevents a hit.
- R10: `hit` is high in the same cycle as a valid fetch that matches, and is low whenever `fetch_valid` is low.
- R11: A write to either register takes effect from the cycle after the write edge. Writing one register keeps the contents of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| val_we | input | 1 | Write strobe for the breakpoint value register |
| val_wdata | input | 64 | New breakpoint value |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 32 | New control word (enable bit 0, select bits 8:5, type bits 23:20) |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | 64 | Start address of the fetched instruction |
| hit | output | 1 | The fetch matches the armed breakpoint |

## Verification
Some properties are checked on every cycle against the stored raw registers. A hit only ever comes with a valid fetch, an enabled control word and an address-match type. A hit fetch agrees with the value register in bits 63:2 and has bit 0 clear. Whether the half-word select moves the match point, whether illegal select codes disarm the breakpoint, and whether each type code is refused can only be shown by the bench. Its directed scenarios program specific register pairs and probe the exact, offset and overlapping addresses. The same goes for write ordering between the two registers.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

    // Control word field positions
    localparam int unsigned EN_BIT   = 0;
    localparam int unsigned SEL_LO   = 5;
    localparam int unsigned SEL_W    = 4;
    localparam int unsigned KIND_LO  = 20;
    localparam int unsigned KIND_W   = 4;
    localparam int unsigned CTL_MINW = KIND_LO + KIND_W;

    typedef enum logic [KIND_W-1:0] {
        KIND_ADDR_FREE   = 4'd0,
        KIND_ADDR_CHAIN  = 4'd1
    } bp_kind_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_LOW_HALF  = 4'b0011,
        SEL_HIGH_HALF = 4'b1100,
        SEL_FULL_WORD = 4'b1111
    } bp_sel_e;

    typedef struct packed {
        logic armed;
        logic plus2;
    } bp_mode_t;

    function automatic bp_mode_t decode_ctl(input logic [CTL_MINW-1:0] c);
        bp_mode_t m;
        logic [KIND_W-1:0] kind;
        logic [SEL_W-1:0]  sel;
        logic kind_ok;
        logic sel_ok;
        kind    = c[KIND_LO +: KIND_W];
        sel     = c[SEL_LO +: SEL_W];
        kind_ok = (kind == KIND_ADDR_FREE) || (kind == KIND_ADDR_CHAIN);
        sel_ok  = (sel == SEL_LOW_HALF) || (sel == SEL_HIGH_HALF) ||
                  (sel == SEL_FULL_WORD);
        m.armed = c[EN_BIT] && kind_ok && sel_ok;
        m.plus2 = (sel == SEL_HIGH_HALF);
        return m;
    endfunction

endpackage

// File: rtl/ibp_regfile.sv
module ibp_regfile #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned CTL_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              val_we,
    input  logic [ADDR_W-1:0] val_wdata,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [ADDR_W-1:0] val_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [ADDR_W-1:0] val_nx,
    output logic [CTL_W-1:0]  ctl_nx,
    output logic              upd
);
    always_comb begin
        val_nx = val_we ? val_wdata : val_q;
        ctl_nx = ctl_we ? ctl_wdata : ctl_q;
        upd    = val_we || ctl_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
            ctl_q <= '0;
        end else begin
            val_q <= val_nx;
            ctl_q <= ctl_nx;
        end
    end
endmodule

// File: rtl/ibp_decode.sv
module ibp_decode
    import ibp_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned CTL_W  = 32
) (
    input  logic [ADDR_W-1:0] val_in,
    input  logic [CTL_W-1:0]  ctl_in,
    output logic              armed,
    output logic [ADDR_W-1:0] cmp_addr
);
    bp_mode_t mode;

    always_comb begin
        mode     = decode_ctl(ctl_in[CTL_MINW-1:0]);
        armed    = mode.armed;
        cmp_addr = {val_in[ADDR_W-1:2], mode.plus2, 1'b0};
    end
endmodule

// File: rtl/ibp_match.sv
module ibp_match #(
    parameter int unsigned ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              armed_nx,
    input  logic [ADDR_W-1:0] addr_nx,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              hit
);
    logic              armed_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            addr_q  <= '0;
        end else if (upd) begin
            armed_q <= armed_nx;
            addr_q  <= addr_nx;
        end
    end

    always_comb hit = fetch_valid && armed_q && (fetch_addr == addr_q);
endmodule

// File: rtl/ibp_comparator.sv
module ibp_comparator
    import ibp_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned CTL_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              val_we,
    input  logic [ADDR_W-1:0] val_wdata,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] val_q;
    logic [CTL_W-1:0]  ctl_q;
    logic [ADDR_W-1:0] val_nx;
    logic [CTL_W-1:0]  ctl_nx;
    logic              upd;
    logic              armed_nx;
    logic [ADDR_W-1:0] addr_nx;

    ibp_regfile #(.ADDR_W(ADDR_W), .CTL_W(CTL_W)) u_regs (
        .clk(clk), .rst(rst),
        .val_we(val_we), .val_wdata(val_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .val_q(val_q), .ctl_q(ctl_q),
        .val_nx(val_nx), .ctl_nx(ctl_nx), .upd(upd)
    );

    ibp_decode #(.ADDR_W(ADDR_W), .CTL_W(CTL_W)) u_dec (
        .val_in(val_nx), .ctl_in(ctl_nx),
        .armed(armed_nx), .cmp_addr(addr_nx)
    );

    ibp_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst(rst), .upd(upd),
        .armed_nx(armed_nx), .addr_nx(addr_nx),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .hit(hit)
    );
endmodule

// File: rtl/ibp_checker.sv
module ibp_checker #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned CTL_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              hit,
    input logic [ADDR_W-1:0] val_q,
    input logic [CTL_W-1:0]  ctl_q
);
    // R10
    hit_needs_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> fetch_valid);

    // R2
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> ctl_q[0]);

    // R4
    hit_kind_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (ctl_q[23:21] == 3'b000));

    // R9
    hit_upper_bits_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (fetch_addr[ADDR_W-1:2] == val_q[ADDR_W-1:2]));

    // R8
    hit_halfword_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (fetch_addr[0] == 1'b0));

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> !hit);
endmodule

bind ibp_comparator ibp_checker #(.ADDR_W(ADDR_W), .CTL_W(CTL_W)) u_chk (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .hit(hit), .val_q(val_q), .ctl_q(ctl_q)
);

// File: tb/tb_ibp_comparator.sv
module tb_ibp_comparator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        val_we = 1'b0;
    logic [63:0] val_wdata = '0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        fetch_valid = 1'b0;
    logic [63:0] fetch_addr = '0;
    logic        hit;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    ibp_comparator dut (
        .clk(clk), .rst(rst),
        .val_we(val_we), .val_wdata(val_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .hit(hit)
    );

    function automatic logic [31:0] mk_ctl(input logic en, input logic [3:0] kind,
                                           input logic [3:0] sel);
        return 32'(en) | (32'(sel) << 5) | (32'(kind) << 20);
    endfunction

    task automatic put_val(input logic [63:0] v);
        @(negedge clk);
        val_we = 1'b1; val_wdata = v;
        @(negedge clk);
        val_we = 1'b0;
    endtask

    task automatic put_ctl(input logic [31:0] c);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = c;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic probe(input logic v, input logic [63:0] a, input logic exp,
                         input string tag);
        @(negedge clk);
        fetch_valid = v; fetch_addr = a;
        #1;
        total++;
        if (hit !== exp) begin
            bad++;
            $display("FAIL %s addr=%h valid=%b hit=%b expected=%b", tag, a, v, hit, exp);
        end
        fetch_valid = 1'b0;
    endtask

    task automatic t_reset();
        probe(1'b1, 64'h0, 1'b0, "R1 reset disarmed at 0");
        probe(1'b1, 64'h2, 1'b0, "R1 reset disarmed at 2");
    endtask

    task automatic t_low_half();
        put_val(64'h1003);
        put_ctl(mk_ctl(1'b1, 4'd0, 4'b0011));
        probe(1'b1, 64'h1000, 1'b1, "R5 R3 sel0011 base");
        probe(1'b1, 64'h1002, 1'b0, "R8 sel0011 at base+2");
        probe(1'b1, 64'h1003, 1'b0, "R8 raw value address");
        probe(1'b0, 64'h1000, 1'b0, "R10 fetch_valid low");
        put_ctl(mk_ctl(1'b1, 4'd0, 4'b1111));
        probe(1'b1, 64'h1000, 1'b1, "R5 sel1111 base");
        probe(1'b1, 64'h1002, 1'b0, "R8 sel1111 at base+2");
    endtask

    task automatic t_high_half();
        put_ctl(mk_ctl(1'b1, 4'd1, 4'b1100));
        probe(1'b1, 64'h1002, 1'b1, "R6 sel1100 base+2");
        probe(1'b1, 64'h1000, 1'b0, "R8 sel1100 at base");
    endtask

    task automatic t_enable();
        put_ctl(mk_ctl(1'b0, 4'd0, 4'b0011));
        probe(1'b1, 64'h1000, 1'b0, "R2 enable clear");
    endtask

    task automatic t_kinds();
        put_ctl(mk_ctl(1'b1, 4'd1, 4'b0011));
        probe(1'b1, 64'h1000, 1'b1, "R3 linked address type");
        for (int k = 2; k < 16; k++) begin
            put_ctl(mk_ctl(1'b1, 4'(k), 4'b0011));
            probe(1'b1, 64'h1000, 1'b0, $sformatf("R4 type %0d", k));
        end
    endtask

    task automatic t_selects();
        logic [3:0] bad_sel [5] = '{4'b0000, 4'b0001, 4'b0101, 4'b1110, 4'b1000};
        foreach (bad_sel[i]) begin
            put_ctl(mk_ctl(1'b1, 4'd0, bad_sel[i]));
            probe(1'b1, 64'h1000, 1'b0, $sformatf("R7 sel %b base", bad_sel[i]));
            probe(1'b1, 64'h1002, 1'b0, $sformatf("R7 sel %b base+2", bad_sel[i]));
        end
    endtask

    task automatic t_wide();
        put_val(64'h8000_0000_0000_1001);
        put_ctl(mk_ctl(1'b1, 4'd0, 4'b0011));
        probe(1'b1, 64'h0000_0000_0000_1000, 1'b0, "R9 bit63 differs");
        probe(1'b1, 64'h8000_0000_0000_1000, 1'b1, "R9 full match");
    endtask

    task automatic t_order();
        put_ctl(mk_ctl(1'b1, 4'd0, 4'b1100));
        put_val(64'h2000);
        probe(1'b1, 64'h2002, 1'b1, "R11 value write keeps control");
        probe(1'b1, 64'h8000_0000_0000_1002, 1'b0, "R11 old value gone");
        // write then fetch on the very next cycle
        @(negedge clk);
        val_we = 1'b1; val_wdata = 64'h3000;
        @(negedge clk);
        val_we = 1'b0;
        fetch_valid = 1'b1; fetch_addr = 64'h3002;
        #1;
        total++;
        if (hit !== 1'b1) begin
            bad++;
            $display("FAIL R11 next-cycle effect hit=%b expected=1", hit);
        end
        fetch_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_low_half();
        t_high_half();
        t_enable();
        t_kinds();
        t_selects();
        t_wide();
        t_order();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule